// File: doc/BRIEF.md
# Clock Frequency Accuracy Monitor

This block checks the frequency of one clock against a second, trusted clock. A target counter runs freely on the clock being checked. The trusted clock, called the reference clock, defines a measurement window that is a set number of its own cycles long. When a window ends, the block takes the number of target edges seen inside it and compares that number with a lower limit and an upper limit. It then raises a completion flag and, if the count is outside the limits, a range-error flag.

Software sets up the block through a small register interface in the reference clock domain. It writes the window length, the two limits and a control word, then reads the captured count and the status flags. The block can take a single measurement or run windows back to back. Each flag drives an interrupt line through its own enable bit.

The target count crosses into the reference domain as a Gray code. For this reason the target clock must run slower than the reference clock.

Top module: `fcm_clock_monitor`

## Requirements
- R1: A window lasts exactly N reference cycles, where N is the value written at address 1. The captured count equals the number of rising target edges that fall within those N reference periods.
- R2: The target count crosses into the reference domain as a Gray code. Each synchronized sample differs from the previous sample in at most one bit. The captured count is read at address 5.
- R3: Status bit 0 (done) sets at the end of every window. Status is read at address 4.
- R4: Status bit 1 (range error) sets when the count is below the lower limit (address 2) or above the upper limit (address 3). A count equal to either limit does not set it.
- R5: Both status flags stay set until cleared. Writing a 1 to a status bit clears that bit. A new event in the same cycle as a clear keeps the flag set.
- R6: irq_done is the done flag ANDed with control bit 2. irq_range is the range-error flag ANDed with control bit 3.
- R7: Control (address 0) bit 0 starts a measurement. When control bit 1 is 0, bit 0 clears itself after one window and then reads back as 0.
- R8: When control bit 1 is 1, the next window starts on the same edge that captures the current one. Clearing bit 0 stops the window in progress, and that window reports nothing.
- R9: A count that reaches 2^CNT_W-1 saturates at that value. It is always reported as a range error, even when it lies between the limits.
- R10: After reset, every register reads 0 and both interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock, which also clocks the register interface |
| ref_rst_n | input | 1 | Active-low asynchronous reset, reference domain |
| tgt_clk | input | 1 | Clock under measurement |
| tgt_rst_n | input | 1 | Active-low asynchronous reset, target domain |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W (16) | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DATA_W (16) | Register read data, combinational from rd_addr |
| irq_done | output | 1 | Measurement-complete interrupt |
| irq_range | output | 1 | Out-of-range interrupt |

## Verification
The assertions check the following on every cycle:
- the synchronized Gray value moves by at most one bit;
- the window down counter steps down by one;
- each window end sets the done flag, and sets the range flag for a bad or saturated count;
- the flags stay set until a clear;
- the run bit clears in single-shot mode and stays set in continuous mode.

Only the bench scenarios can show the rest:
- that the captured count is exact for several clock ratios;
- that both limits are inclusive;
- that a masked interrupt stays low;
- that stopping a continuous run cancels the open window;
- that saturation is reported.

// File: rtl/fcm_pkg.sv
`timescale 1ns/1ps
package fcm_pkg;
  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_WIN   = 3'd1;
  localparam logic [2:0] A_LOW   = 3'd2;
  localparam logic [2:0] A_HIGH  = 3'd3;
  localparam logic [2:0] A_STAT  = 3'd4;
  localparam logic [2:0] A_COUNT = 3'd5;

  // Control word. The first member is the most significant bit, so run is bit 0.
  typedef struct packed {
    logic rng_ie;
    logic done_ie;
    logic cont;
    logic run;
  } ctrl_t;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // The range is inclusive at both ends. A saturated count always fails.
  function automatic logic range_fail(input logic [31:0] c, input logic [31:0] lo,
                                      input logic [31:0] hi, input logic sat);
    return (c < lo) || (c > hi) || sat;
  endfunction
endpackage

// File: rtl/fcm_tgt_count.sv
`timescale 1ns/1ps
module fcm_tgt_count import fcm_pkg::*; #(
  parameter int IW = 18
) (
  input  logic          tgt_clk,
  input  logic          tgt_rst_n,
  output logic [IW-1:0] gray_o
);
  logic [IW-1:0] bin_q;
  logic [IW-1:0] bin_nx;

  assign bin_nx = bin_q + IW'(1);

  // The Gray value is registered, so the synchronizer never sees a decode glitch.
  always_ff @(posedge tgt_clk or negedge tgt_rst_n) begin
    if (!tgt_rst_n) begin
      bin_q  <= '0;
      gray_o <= '0;
    end else begin
      bin_q  <= bin_nx;
      gray_o <= IW'(bin2gray(32'(bin_nx)));
    end
  end

  AST_TGT_GRAY_STEP: assert property (@(posedge tgt_clk) disable iff (!tgt_rst_n)
    $countones(gray_o ^ $past(gray_o)) <= 1); // R2
endmodule

// File: rtl/fcm_gray_sync.sv
`timescale 1ns/1ps
module fcm_gray_sync import fcm_pkg::*; #(
  parameter int IW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] gray_i,
  output logic [IW-1:0] bin_o
);
  logic [IW-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  assign bin_o = IW'(gray2bin(32'(s2_q)));

  // This holds only when the target clock is slower than the reference clock.
  AST_SYNC_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(s2_q ^ $past(s2_q)) <= 1); // R2
endmodule

// File: rtl/fcm_window.sv
`timescale 1ns/1ps
module fcm_window #(
  parameter int CNT_W = 16,
  parameter int WIN_W = 16,
  parameter int IW    = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [WIN_W-1:0] win_len,
  input  logic [IW-1:0]    tgt_now,
  output logic             win_end,
  output logic [CNT_W-1:0] meas_val,
  output logic             meas_sat
);
  localparam logic [IW-1:0] CMAX = {{(IW-CNT_W){1'b0}}, {CNT_W{1'b1}}};

  logic             active_q;
  logic [WIN_W-1:0] dcnt_q;
  logic [WIN_W-1:0] load_v;
  logic [IW-1:0]    base_q;
  logic [IW-1:0]    delta;
  logic             win_start;

  // A zero length acts as one cycle, so the down counter never wraps.
  assign load_v    = (win_len == '0) ? WIN_W'(1) : win_len;
  assign win_start = run && !active_q;
  assign win_end   = run && active_q && (dcnt_q == WIN_W'(1));
  assign delta     = tgt_now - base_q;
  assign meas_sat  = (delta >= CMAX);
  assign meas_val  = meas_sat ? {CNT_W{1'b1}} : delta[CNT_W-1:0];

  // The closing sample also opens the next window, so continuous windows have no gap.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      dcnt_q   <= '0;
      base_q   <= '0;
    end else if (!run) begin
      active_q <= 1'b0;
    end else if (win_start || win_end) begin
      active_q <= 1'b1;
      dcnt_q   <= load_v;
      base_q   <= tgt_now;
    end else if (active_q) begin
      dcnt_q   <= dcnt_q - WIN_W'(1);
    end
  end

  AST_WIN_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    run && active_q && !win_end |=> dcnt_q == $past(dcnt_q) - WIN_W'(1)); // R1
  AST_WIN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    win_start |=> active_q && dcnt_q == $past(load_v)); // R1
endmodule

// File: rtl/fcm_regs.sv
`timescale 1ns/1ps
module fcm_regs import fcm_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int WIN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              win_end,
  input  logic [CNT_W-1:0]  meas_val,
  input  logic              meas_sat,
  output logic              run,
  output logic [WIN_W-1:0]  win_len,
  output logic              irq_done,
  output logic              irq_range
);
  ctrl_t            ctrl_q;
  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] lo_q, hi_q, cnt_q;
  logic             done_f, rng_f;
  logic             wr_ctrl, wr_win, wr_lo, wr_hi, wr_stat;
  logic [1:0]       clr;
  logic             meas_bad;
  logic             unused_wr_bits;

  assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
  assign wr_win   = wr_en && (wr_addr == A_WIN);
  assign wr_lo    = wr_en && (wr_addr == A_LOW);
  assign wr_hi    = wr_en && (wr_addr == A_HIGH);
  assign wr_stat  = wr_en && (wr_addr == A_STAT);
  assign clr      = wr_stat ? wr_data[1:0] : 2'b00;
  assign meas_bad = range_fail(32'(meas_val), 32'(lo_q), 32'(hi_q), meas_sat);
  assign unused_wr_bits = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      win_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      cnt_q  <= '0;
      done_f <= 1'b0;
      rng_f  <= 1'b0;
    end else begin
      if (wr_ctrl)                      ctrl_q     <= ctrl_t'(wr_data[3:0]);
      else if (win_end && !ctrl_q.cont) ctrl_q.run <= 1'b0;
      if (wr_win) win_q <= wr_data[WIN_W-1:0];
      if (wr_lo)  lo_q  <= wr_data[CNT_W-1:0];
      if (wr_hi)  hi_q  <= wr_data[CNT_W-1:0];
      if (win_end) cnt_q <= meas_val;
      // A new event wins over a clear in the same cycle.
      done_f <= win_end | (done_f & ~clr[0]);
      rng_f  <= (win_end & meas_bad) | (rng_f & ~clr[1]);
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:  rd_data = DATA_W'(ctrl_q);
      A_WIN:   rd_data = DATA_W'(win_q);
      A_LOW:   rd_data = DATA_W'(lo_q);
      A_HIGH:  rd_data = DATA_W'(hi_q);
      A_STAT:  rd_data = DATA_W'({rng_f, done_f});
      A_COUNT: rd_data = DATA_W'(cnt_q);
      default: rd_data = '0;
    endcase
  end

  assign run       = ctrl_q.run;
  assign win_len   = win_q;
  assign irq_done  = done_f & ctrl_q.done_ie;
  assign irq_range = rng_f & ctrl_q.rng_ie;

  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> done_f); // R3
  AST_RANGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    win_end && meas_bad |=> rng_f); // R4
  AST_RANGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    win_end && !meas_bad && !rng_f |=> !rng_f); // R4
  AST_SAT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    win_end && meas_sat |=> rng_f); // R9
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done_f && !(wr_stat && wr_data[0]) |=> done_f); // R5
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    win_end && !ctrl_q.cont && !wr_ctrl |=> !ctrl_q.run); // R7
  AST_CONT_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    win_end && ctrl_q.cont && !wr_ctrl |=> ctrl_q.run); // R8
endmodule

// File: rtl/fcm_clock_monitor.sv
`timescale 1ns/1ps
module fcm_clock_monitor #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int WIN_W  = 16
) (
  input  logic              ref_clk,
  input  logic              ref_rst_n,
  input  logic              tgt_clk,
  input  logic              tgt_rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_done,
  output logic              irq_range
);
  // Two headroom bits let the modular difference exceed the saturation point.
  localparam int IW = CNT_W + 2;

  logic [IW-1:0]    tgt_gray;
  logic [IW-1:0]    tgt_now;
  logic             run;
  logic [WIN_W-1:0] win_len;
  logic             win_end;
  logic [CNT_W-1:0] meas_val;
  logic             meas_sat;

  fcm_tgt_count #(.IW(IW)) u_tgt (
    .tgt_clk   (tgt_clk),
    .tgt_rst_n (tgt_rst_n),
    .gray_o    (tgt_gray)
  );

  fcm_gray_sync #(.IW(IW)) u_sync (
    .clk    (ref_clk),
    .rst_n  (ref_rst_n),
    .gray_i (tgt_gray),
    .bin_o  (tgt_now)
  );

  fcm_window #(.CNT_W(CNT_W), .WIN_W(WIN_W), .IW(IW)) u_win (
    .clk      (ref_clk),
    .rst_n    (ref_rst_n),
    .run      (run),
    .win_len  (win_len),
    .tgt_now  (tgt_now),
    .win_end  (win_end),
    .meas_val (meas_val),
    .meas_sat (meas_sat)
  );

  fcm_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .WIN_W(WIN_W)) u_regs (
    .clk       (ref_clk),
    .rst_n     (ref_rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .win_end   (win_end),
    .meas_val  (meas_val),
    .meas_sat  (meas_sat),
    .run       (run),
    .win_len   (win_len),
    .irq_done  (irq_done),
    .irq_range (irq_range)
  );
endmodule

// File: tb/fcm_clock_monitor_test.sv
`timescale 1ns/1ps
module fcm_clock_monitor_test;
  import fcm_pkg::*;
  localparam int DW = 16;
  localparam int CW = 10;
  localparam int WW = 16;
  localparam int CMAXV = (1 << CW) - 1;

  typedef struct {
    int    cnt;
    bit    rng;
    bit    rie;
    string tag;
  } exp_t;

  logic          ref_clk = 1'b0;
  logic          tgt_clk = 1'b0;
  logic          ref_rst_n = 1'b0;
  logic          tgt_rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [2:0]    rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          irq_done, irq_range;

  int   tgt_half = 4;
  int   tests = 0;
  int   fails = 0;
  bit   finished = 0;
  exp_t q[$];

  fcm_clock_monitor #(.DATA_W(DW), .CNT_W(CW), .WIN_W(WW)) uut (
    .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .tgt_clk(tgt_clk), .tgt_rst_n(tgt_rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_done(irq_done), .irq_range(irq_range)
  );

  // 250 MHz reference with rising edges at 2 mod 4 ns. Target edges always fall
  // at 1 mod 4 ns, so the two clocks never share an edge.
  initial forever #2 ref_clk = ~ref_clk;
  initial begin
    #1;
    forever #(tgt_half) tgt_clk = ~tgt_clk;
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge ref_clk);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge ref_clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [DW-1:0] d);
    @(negedge ref_clk);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  // Driver: computes the expected result from the clock ratio and pushes it to the queue.
  task automatic measure(input int half, input int n, input int lo, input int hi,
                         input bit cont, input int nwin, input bit rie, input string tag);
    int raw, c;
    bit r;
    exp_t e;
    logic [DW-1:0] d;
    while (q.size() != 0) @(negedge ref_clk);
    tgt_half = half;
    repeat (20) @(negedge ref_clk);
    raw = (n * 4) / (2 * half);
    c = (raw > CMAXV) ? CMAXV : raw;
    r = (c < lo) || (c > hi) || (c == CMAXV);
    bus_wr(A_WIN, DW'(n));
    bus_wr(A_LOW, DW'(lo));
    bus_wr(A_HIGH, DW'(hi));
    for (int i = 0; i < nwin; i++) begin
      e.cnt = c; e.rng = r; e.rie = rie; e.tag = tag;
      q.push_back(e);
    end
    bus_wr(A_CTRL, {12'd0, rie, 1'b1, cont, 1'b1});
    while (q.size() != 0) @(negedge ref_clk);
    if (cont) begin
      bus_wr(A_CTRL, {12'd0, rie, 1'b1, 2'b00});
      repeat (2 * n + 10) @(negedge ref_clk);
      bus_rd(A_STAT, d);
      check("R8", int'(d[1:0]), 0, "status after stopping continuous run");
      check("R8", int'(irq_done), 0, "irq_done after stopping continuous run");
    end else begin
      bus_rd(A_CTRL, d);
      check("R7", int'(d[0]), 0, "run bit after single shot");
    end
  endtask

  // Monitor: on each completion, compare against the front of the queue, then clear.
  initial begin
    exp_t e;
    logic [DW-1:0] d;
    while (!ref_rst_n) @(negedge ref_clk);
    forever begin
      @(posedge irq_done);
      if (q.size() == 0) begin
        check("R3", 1, 0, "completion without a pending measurement");
        continue;
      end
      e = q[0];
      bus_rd(A_COUNT, d);
      check(e.tag, int'(d), e.cnt, "captured count");
      bus_rd(A_STAT, d);
      check("R3", int'(d[0]), 1, "done flag");
      check("R4", int'(d[1]), int'(e.rng), "range flag");
      check("R6", int'(irq_range), int'(e.rng & e.rie), "irq_range gating");
      bus_wr(A_STAT, 16'h0003);
      bus_rd(A_STAT, d);
      check("R5", int'(d[1:0]), 0, "status after write-one-to-clear");
      check("R6", int'(irq_done), 0, "irq_done after clear");
      void'(q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge ref_clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    repeat (5) @(negedge ref_clk);
    ref_rst_n = 1'b1;
    tgt_rst_n = 1'b1;
    // R10: every register reads zero and both interrupt lines are low after reset.
    for (int a = 0; a < 6; a++) begin
      bus_rd(3'(a), d);
      check("R10", int'(d), 0, "register after reset");
    end
    check("R10", int'(irq_done), 0, "irq_done after reset");
    check("R10", int'(irq_range), 0, "irq_range after reset");

    measure(4, 64, 30, 34, 1'b0, 1, 1'b1, "R2");  // 32 edges, in range
    measure(4, 64, 33, 40, 1'b0, 1, 1'b1, "R4");  // 32 below the lower limit
    measure(8, 64, 0, 15, 1'b0, 1, 1'b1, "R4");   // 16 above the upper limit
    measure(4, 40, 20, 20, 1'b0, 1, 1'b1, "R4");  // both bounds inclusive
    measure(12, 96, 10, 20, 1'b0, 1, 1'b1, "R1"); // 16 edges, slower target
    measure(4, 48, 0, 100, 1'b1, 3, 1'b1, "R8");  // three back-to-back windows
    measure(4, 64, 0, 10, 1'b0, 1, 1'b0, "R6");   // range interrupt masked
    measure(4, 2400, 0, CMAXV, 1'b0, 1, 1'b1, "R9"); // saturates at the maximum

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule